// File: doc/BRIEF.md
# Trigger-Slice Scrolling Readout Buffer

The block keeps a rolling history of one data word per bunch crossing in a circular memory. The write pointer advances on every crossing strobe and wraps around the memory, so the memory always holds the most recent crossings. When a level-1 accept arrives, the block captures a start address: the live write pointer minus a programmable trigger-slice offset. It then replays a run of consecutive stored slices from that address into a show-ahead output FIFO. The run can include crossings before the accept, the accept crossing itself, and crossings after it.

Accepts that arrive while a replay is running are queued, each with its own start address and slice count. A slice that lies after the accept is read only once it has been written. The output FIFO stalls the replay when it is full and never loses a word. A busy flag with separate set and clear levels, based on the FIFO fill level, tells upstream logic to hold off. The live write pointer is brought out so that spy logic can read it.

Top module: `slice_readout_buf`

## Requirements
- R1: The write pointer `wr_ptr_o` is 0 after reset and advances by one, modulo 64, on each cycle with `bx_valid_i` high; the word on `bx_data_i` is stored at the old pointer value.
- R2: On an accept, the first slice read is at address (write pointer − `trig_slice_i`) modulo 64. The accept crossing is the word written in the same cycle as `accept_i`, so an offset of k starts k crossings before the accept.
- R3: Each accept yields exactly the programmed number of slices, read at consecutive increasing addresses and delivered in that order.
- R4: The slice-count register is 1 after reset and takes the value of `slices_i` in a cycle with `slices_we_i` high.
- R5: A slice at or after the live write pointer is not read until it has been written; with crossings paused, the readout stops at the last written slice and resumes when crossings resume.
- R6: Accepts that arrive during a readout are queued, up to 4 outstanding, and are served in arrival order with their own start address and slice count.
- R7: The output FIFO (16 words) presents its head word on `out_data_o` with `out_valid_o` high, and drops the head on a cycle with `out_pop_i` high. When the FIFO is full, the replay stalls and no word is lost or reordered.
- R8: `busy_o` rises once the FIFO fill reaches `busy_on_i`, stays high while the fill is above `busy_off_i`, and falls once the fill is at or below `busy_off_i`. It is low after reset.
- R9: A replay window that crosses address 63 continues at address 0 and keeps time order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_data_i | input | DATA_W | Per-crossing data word |
| bx_valid_i | input | 1 | Crossing strobe; writes the word and advances the pointer |
| accept_i | input | 1 | Level-1 accept pulse |
| trig_slice_i | input | AW | Trigger-slice offset subtracted from the write pointer |
| slices_we_i | input | 1 | Load strobe for the slice-count register |
| slices_i | input | AW | New slice count |
| busy_on_i | input | CW | Fill level at which busy sets |
| busy_off_i | input | CW | Fill level at or below which busy clears |
| out_pop_i | input | 1 | Drops the output FIFO head |
| out_data_o | output | DATA_W | Output FIFO head word |
| out_valid_o | output | 1 | Output FIFO not empty |
| wr_ptr_o | output | AW | Live write pointer |
| busy_o | output | 1 | Busy flag with hysteresis |

## Verification
The assertions assume that a queued start address is not overrun by the write pointer before it is served. The pointer distance used to decide that a slice has been written is therefore never ambiguous. They also assume that `trig_slice_i` plus the slice count stays well below the memory depth, and that `busy_off_i` is below `busy_on_i`. The stimulus follows these assumptions. Windows are at most 20 slices with small offsets. Crossings are paused while the FIFO is held full, so the stalled replay is never lapped. Each scenario drains fully before the next one starts.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic {RD_IDLE, RD_RUN} rd_state_e;
endpackage

// File: rtl/srb_fifo.sv
module srb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> $stable(cnt_q));
  // R7
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> cnt_q == '0);
endmodule

// File: rtl/srb_slice_ram.sv
module srb_slice_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] ram_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) ram_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= ram_q[raddr_i];
  end
endmodule

// File: rtl/srb_reader.sv
module srb_reader
  import srb_pkg::*;
#(
  parameter int AW        = 6,
  parameter int OUT_DEPTH = 16,
  localparam int CW       = $clog2(OUT_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pend_empty_i,
  input  logic [AW-1:0] pend_start_i,
  input  logic [AW-1:0] pend_n_i,
  output logic          pend_pop_o,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [CW-1:0] out_cnt_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          push_o
);
  localparam logic [CW-1:0] FULL_LVL = CW'(OUT_DEPTH);

  rd_state_e     state_q;
  logic [AW-1:0] addr_q, remain_q;
  logic          push_q;
  logic [CW-1:0] fill;
  logic          written, space;

  // slice counts as written once the pointer has moved past it
  assign written    = (addr_q != wr_ptr_i);
  // count the word still in flight from the RAM read register
  assign fill       = out_cnt_i + {{(CW-1){1'b0}}, push_q};
  assign space      = (fill < FULL_LVL);
  assign rd_en_o    = (state_q == RD_RUN) && (remain_q != '0) && written && space;
  assign pend_pop_o = (state_q == RD_IDLE) && !pend_empty_i;
  assign rd_addr_o  = addr_q;
  assign push_o     = push_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RD_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      push_q   <= 1'b0;
    end else begin
      push_q <= rd_en_o;
      case (state_q)
        RD_IDLE: if (pend_pop_o) begin
          addr_q   <= pend_start_i;
          remain_q <= pend_n_i;
          state_q  <= RD_RUN;
        end
        default: if (remain_q == '0) begin
          state_q <= RD_IDLE;
        end else if (rd_en_o) begin
          addr_q   <= addr_q + 1'b1;
          remain_q <= remain_q - 1'b1;
        end
      endcase
    end
  end

  // R5
  rd_unwritten_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> rd_addr_o != wr_ptr_i);
  // R3
  rd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> rd_addr_o == $past(rd_addr_o) + 1'b1);
  // R7
  rd_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> out_cnt_i < FULL_LVL);
endmodule

// File: rtl/srb_busy.sv
module srb_busy #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] on_i,
  input  logic [CW-1:0] off_i,
  output logic          busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               busy_q <= 1'b0;
    else if (count_i >= on_i)  busy_q <= 1'b1;
    else if (count_i <= off_i) busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && count_i > off_i |=> busy_o);
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && count_i < on_i |=> !busy_o);
endmodule

// File: rtl/slice_readout_buf.sv
module slice_readout_buf #(
  parameter int DATA_W     = 16,
  parameter int MEM_DEPTH  = 64,
  parameter int PEND_DEPTH = 4,
  parameter int OUT_DEPTH  = 16,
  localparam int AW        = $clog2(MEM_DEPTH),
  localparam int CW        = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] bx_data_i,
  input  logic              bx_valid_i,
  input  logic              accept_i,
  input  logic [AW-1:0]     trig_slice_i,
  input  logic              slices_we_i,
  input  logic [AW-1:0]     slices_i,
  input  logic [CW-1:0]     busy_on_i,
  input  logic [CW-1:0]     busy_off_i,
  input  logic              out_pop_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic [AW-1:0]     wr_ptr_o,
  output logic              busy_o
);
  logic [AW-1:0]     wr_ptr_q, n_slices_q;
  logic [2*AW-1:0]   pend_wdata, pend_rdata;
  logic              pend_empty, pend_full, pend_pop;
  logic [$clog2(PEND_DEPTH+1)-1:0] pend_cnt;
  logic              rd_en, out_push, out_empty, out_full;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [CW-1:0]     out_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      n_slices_q <= AW'(1);
    end else begin
      if (bx_valid_i)  wr_ptr_q   <= wr_ptr_q + 1'b1;
      if (slices_we_i) n_slices_q <= slices_i;
    end
  end

  assign wr_ptr_o   = wr_ptr_q;
  assign pend_wdata = {wr_ptr_q - trig_slice_i, n_slices_q};

  srb_slice_ram #(.W(DATA_W), .DEPTH(MEM_DEPTH)) i_ram (
    .clk_i, .we_i(bx_valid_i), .waddr_i(wr_ptr_q), .wdata_i(bx_data_i),
    .re_i(rd_en), .raddr_i(rd_addr), .rdata_o(rd_data));

  srb_fifo #(.W(2*AW), .DEPTH(PEND_DEPTH)) i_pend (
    .clk_i, .rst_ni, .push_i(accept_i), .data_i(pend_wdata), .pop_i(pend_pop),
    .data_o(pend_rdata), .empty_o(pend_empty), .full_o(pend_full), .count_o(pend_cnt));

  srb_reader #(.AW(AW), .OUT_DEPTH(OUT_DEPTH)) i_reader (
    .clk_i, .rst_ni, .pend_empty_i(pend_empty),
    .pend_start_i(pend_rdata[2*AW-1:AW]), .pend_n_i(pend_rdata[AW-1:0]),
    .pend_pop_o(pend_pop), .wr_ptr_i(wr_ptr_q), .out_cnt_i(out_cnt),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .push_o(out_push));

  srb_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) i_out (
    .clk_i, .rst_ni, .push_i(out_push), .data_i(rd_data), .pop_i(out_pop_i),
    .data_o(out_data_o), .empty_o(out_empty), .full_o(out_full), .count_o(out_cnt));

  assign out_valid_o = !out_empty;

  srb_busy #(.CW(CW)) i_busy (
    .clk_i, .rst_ni, .count_i(out_cnt), .on_i(busy_on_i), .off_i(busy_off_i),
    .busy_o(busy_o));

  // R1
  wr_ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bx_valid_i |=> wr_ptr_o == $past(wr_ptr_o) + 1'b1);
  // R1
  wr_ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bx_valid_i |=> $stable(wr_ptr_o));
  // R4
  slices_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slices_we_i |=> $stable(n_slices_q));
  // R6
  pend_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_full && accept_i && !pend_pop |=> $stable(pend_cnt));
  // R7
  out_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_full |-> !out_push);
endmodule

// File: tb/test_slice_readout_buf.sv
module test_slice_readout_buf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bx_data;
  logic        bx_valid, accept = 1'b0, slices_we = 1'b0, pop = 1'b1;
  logic [5:0]  trig = '0, slices = '0, wr_ptr;
  logic [4:0]  busy_on = 5'd6, busy_off = 5'd2;
  logic [15:0] out_data;
  logic        out_valid, busy;
  logic        bx_run = 1'b0, done = 1'b0;
  int          bx_cnt = 0, cur_n = 1, n_chk = 0, n_fail = 0;
  logic [15:0] got_q[$], exp_q[$];

  always #5 clk = ~clk;

  assign bx_valid = bx_run;
  assign bx_data  = 16'(bx_cnt);

  always @(posedge clk) begin
    if (bx_valid) bx_cnt <= bx_cnt + 1;
    if (pop && out_valid) got_q.push_back(out_data);
  end

  slice_readout_buf i_slice_readout_buf (
    .clk_i(clk), .rst_ni(rst_n), .bx_data_i(bx_data), .bx_valid_i(bx_valid),
    .accept_i(accept), .trig_slice_i(trig), .slices_we_i(slices_we), .slices_i(slices),
    .busy_on_i(busy_on), .busy_off_i(busy_off), .out_pop_i(pop),
    .out_data_o(out_data), .out_valid_o(out_valid), .wr_ptr_o(wr_ptr), .busy_o(busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(got_q.size() == exp_q.size(), {req, " word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++)
      if (i < got_q.size()) check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic set_slices(input int v);
    @(negedge clk); slices_we = 1'b1; slices = 6'(v);
    @(negedge clk); slices_we = 1'b0;
    cur_n = v;
  endtask

  task automatic fire(input bit pause_after);
    int n;
    @(negedge clk); accept = 1'b1;
    n = bx_cnt;
    for (int k = 0; k < cur_n; k++) exp_q.push_back(16'(n - int'(trig) + k));
    @(negedge clk); accept = 1'b0;
    if (pause_after) bx_run = 1'b0;
  endtask

  task automatic drain();
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset();
    check(wr_ptr == 6'd0, "R1 reset pointer", wr_ptr, 0);
    check(out_valid == 1'b0, "R7 reset empty", out_valid, 0);
    check(busy == 1'b0, "R8 reset busy", busy, 0);
  endtask

  task automatic t_default_count();
    trig = 6'd0;
    fire(1'b0); drain();
    compare("R4 default single slice");
  endtask

  task automatic t_pointer();
    @(negedge clk);
    check(int'(wr_ptr) == bx_cnt % 64, "R1 pointer tracks crossings", wr_ptr, bx_cnt % 64);
  endtask

  task automatic t_offset();
    set_slices(1); trig = 6'd2;
    fire(1'b0); drain();
    compare("R2 offset start");
  endtask

  task automatic t_centred();
    set_slices(3); trig = 6'd1;
    fire(1'b0); drain();
    compare("R3 centred window");
  endtask

  task automatic t_queue();
    set_slices(3); trig = 6'd1;
    fire(1'b0); fire(1'b0); drain();
    compare("R6 queued accepts");
  endtask

  task automatic t_wrap();
    set_slices(3); trig = 6'd3;
    while (bx_cnt % 64 != 1) @(negedge clk);
    fire(1'b0); drain();
    compare("R9 window wraps");
  endtask

  task automatic t_wait_written();
    set_slices(3); trig = 6'd0;
    fire(1'b1);
    repeat (20) @(negedge clk);
    check(got_q.size() == 1, "R5 stops at last written", got_q.size(), 1);
    bx_run = 1'b1;
    drain();
    compare("R5 resumes after write");
  endtask

  task automatic pop_one();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_backpressure();
    set_slices(20); trig = 6'd0;
    @(negedge clk); pop = 1'b0;
    fire(1'b0);
    repeat (30) @(negedge clk);
    bx_run = 1'b0;
    repeat (20) @(negedge clk);
    check(busy == 1'b1, "R8 busy at full", busy, 1);
    check(got_q.size() == 0, "R7 nothing popped while held", got_q.size(), 0);
    for (int i = 0; i < 4; i++) pop_one();
    repeat (10) @(negedge clk);
    for (int i = 0; i < 13; i++) pop_one();
    check(busy == 1'b1, "R8 holds above clear level", busy, 1);
    pop_one();
    check(busy == 1'b0, "R8 clears at clear level", busy, 0);
    pop_one(); pop_one();
    compare("R7 no loss under full");
    @(negedge clk); pop = 1'b1; bx_run = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); bx_run = 1'b1;
    repeat (10) @(negedge clk);
    t_default_count();
    t_pointer();
    t_offset();
    t_centred();
    t_queue();
    t_wrap();
    t_wait_written();
    t_backpressure();
    t_pointer();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule